// File: doc/BRIEF.md
# E1 Biframe Alignment Monitor

This block sits on the system-side serial E1 stream before the transmit framer. It checks that the stream keeps the two-frame rhythm that carries Sa bits. Frames that carry Sa bits must show a 1 in bit 2 of time slot 0. Each of those frames must be followed directly by a frame that shows a 0 there. While this rhythm holds, Sa bits from the system line up with the Sa positions on the transmit line.

A per-bit counter is restarted by a frame-start strobe. The strobe marks bit 1 of time slot 0, and the bit that follows it is sampled. A small state machine compares the sampled bit with the frame type it expects. The first mismatch puts it in a search state, and the loss flag rises. In that state it looks for a 1 directly followed by a 0. When it finds one, it drops the loss flag, gives a one-cycle realignment pulse and goes back to tracking.

While alignment is lost and the system is the source of Sa/Si bits, a corrupt indication is raised for the outgoing Sa/Si data. A mode input switches the check off. While it is off, the block is held aligned.

Top module: `e1_biframe_mon`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, the block reports: loss_o=1 (search state), realign_o=0, ftype_vld_o=0.
- R2: The bit on data_i one clock after a frame_start_i cycle is the frame-type bit. frame_type_o takes that bit from the following clock edge onward (1 = Sa-carrying frame, 0 = alignment frame).
- R3: ftype_vld_o goes high at the clock edge that ends the last bit of time slot 0 (frame position SLOT_BITS-1). It stays high through the next frame_start_i cycle and is low from the edge after that cycle.
- R4: When aligned, a sampled frame-type bit that differs from the expected one sets loss_o at the clock edge that ends the sample cycle.
- R5: In search, a sampled 1 followed by a sampled 0 in the next frame clears loss_o and pulses realign_o for exactly one cycle, both at the edge after the second sample. No other event raises realign_o.
- R6: When aligned, the expected frame type alternates from frame to frame. After a realignment the next frame is expected to carry Sa (bit 1).
- R7: sa_corrupt_o equals loss_o AND sys_sa_src_i AND mode_en_i at all times.
- R8: While mode_en_i is low, loss_o is low from the next clock edge and realign_o stays low. The expected type follows the sampled bits, so that on re-enable the alternation continues from the last sampled frame.
- R9: Before the first frame_start_i after reset, no sample is taken and ftype_vld_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | High on bit 1 of time slot 0 |
| data_i | input | 1 | System-side serial data |
| mode_en_i | input | 1 | Enables the biframe check |
| sys_sa_src_i | input | 1 | System side is sourcing Sa/Si bits |
| loss_o | output | 1 | Loss of biframe alignment |
| realign_o | output | 1 | One-cycle pulse on new alignment |
| frame_type_o | output | 1 | Sampled type of the current frame (1 = Sa-carrying) |
| ftype_vld_o | output | 1 | frame_type_o is valid |
| sa_corrupt_o | output | 1 | Outgoing Sa/Si data must be treated as corrupt |

## Verification
A wrong expected-type bit shows up at the first sample that follows it. It either raises loss_o on a stream that alternates correctly, or misses a broken alternation, one clock after bit 2 of time slot 0. A fault in the bit-position counter moves the sampling point. This shows within one frame, as a wrong frame_type_o or as ftype_vld_o switching at the wrong position. An exhaustive sweep of every frame-type sequence over seven frames catches these. So does a sweep that mixes in mode-disable frames. In both, each output is compared at the exact cycle after the sample.

// File: rtl/e1bm_pkg.sv
package e1bm_pkg;
  typedef enum logic {
    ST_LOCKED = 1'b0,
    ST_SEARCH = 1'b1
  } align_st_e;

  localparam logic TYPE_SA  = 1'b1;
  localparam logic TYPE_FAS = 1'b0;
endpackage

// File: rtl/e1bm_bit_pos.sv
module e1bm_bit_pos #(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  output logic [POS_W-1:0] pos_o,
  output logic             synced_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] cnt_q, cnt_d;
  logic             synced_q;

  // strobe forces position 0 in its own cycle
  assign pos_o    = frame_start_i ? '0 : cnt_q;
  assign synced_o = synced_q | frame_start_i;
  assign cnt_d    = (pos_o == LAST_POS) ? '0 : pos_o + POS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      synced_q <= synced_o;
    end
  end
endmodule

// File: rtl/e1bm_ts0_tap.sv
module e1bm_ts0_tap #(
  parameter int SLOT_BITS = 8,
  parameter int TAP_POS   = 1,
  parameter int POS_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] pos_i,
  input  logic             synced_i,
  input  logic             frame_start_i,
  input  logic             data_i,
  output logic             smp_vld_o,
  output logic             smp_bit_o,
  output logic             ftype_o,
  output logic             ftype_vld_o
);
  localparam logic [POS_W-1:0] TAP_AT   = POS_W'(TAP_POS);
  localparam logic [POS_W-1:0] SLOT_END = POS_W'(SLOT_BITS - 1);

  logic ftype_q, vld_q;

  assign smp_vld_o   = synced_i && !frame_start_i && (pos_i == TAP_AT);
  assign smp_bit_o   = data_i;
  assign ftype_o     = ftype_q;
  assign ftype_vld_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftype_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      if (smp_vld_o) ftype_q <= data_i;
      if (frame_start_i)                          vld_q <= 1'b0;
      else if (synced_i && pos_i == SLOT_END)     vld_q <= 1'b1;
    end
  end
endmodule

// File: rtl/e1bm_align_fsm.sv
module e1bm_align_fsm
  import e1bm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_en_i,
  input  logic smp_vld_i,
  input  logic smp_bit_i,
  output logic loss_o,
  output logic realign_o
);
  align_st_e st_q;
  logic      exp_q;      // expected type of next sampled frame
  logic      prev_q;     // last bit seen while searching
  logic      prev_vld_q;
  logic      realign_q;

  assign loss_o    = (st_q == ST_SEARCH);
  assign realign_o = realign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_SEARCH;
      exp_q      <= TYPE_SA;
      prev_q     <= 1'b0;
      prev_vld_q <= 1'b0;
      realign_q  <= 1'b0;
    end else if (!mode_en_i) begin
      st_q       <= ST_LOCKED;
      prev_vld_q <= 1'b0;
      realign_q  <= 1'b0;
      if (smp_vld_i) exp_q <= ~smp_bit_i;
    end else begin
      realign_q <= 1'b0;
      if (smp_vld_i) begin
        unique case (st_q)
          ST_LOCKED: begin
            if (smp_bit_i == exp_q) begin
              exp_q <= ~smp_bit_i;
            end else begin
              st_q       <= ST_SEARCH;
              prev_q     <= smp_bit_i;
              prev_vld_q <= 1'b1;
            end
          end
          ST_SEARCH: begin
            if (prev_vld_q && prev_q == TYPE_SA && smp_bit_i == TYPE_FAS) begin
              st_q       <= ST_LOCKED;
              exp_q      <= TYPE_SA;
              realign_q  <= 1'b1;
              prev_vld_q <= 1'b0;
            end else begin
              prev_q     <= smp_bit_i;
              prev_vld_q <= 1'b1;
            end
          end
          default: st_q <= ST_SEARCH;
        endcase
      end
    end
  end
endmodule

// File: rtl/e1_biframe_mon.sv
module e1_biframe_mon #(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 32,
  parameter int TAP_POS   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic data_i,
  input  logic mode_en_i,
  input  logic sys_sa_src_i,
  output logic loss_o,
  output logic realign_o,
  output logic frame_type_o,
  output logic ftype_vld_o,
  output logic sa_corrupt_o
);
  localparam int FRAME_BITS = SLOT_BITS * SLOTS;
  localparam int POS_W      = $clog2(FRAME_BITS);

  logic [POS_W-1:0] pos;
  logic             synced, smp_vld, smp_bit;

  e1bm_bit_pos #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_pos (
    .clk_i, .rst_ni, .frame_start_i,
    .pos_o(pos), .synced_o(synced)
  );

  e1bm_ts0_tap #(.SLOT_BITS(SLOT_BITS), .TAP_POS(TAP_POS), .POS_W(POS_W)) u_tap (
    .clk_i, .rst_ni, .pos_i(pos), .synced_i(synced), .frame_start_i, .data_i,
    .smp_vld_o(smp_vld), .smp_bit_o(smp_bit),
    .ftype_o(frame_type_o), .ftype_vld_o
  );

  e1bm_align_fsm u_fsm (
    .clk_i, .rst_ni, .mode_en_i,
    .smp_vld_i(smp_vld), .smp_bit_i(smp_bit),
    .loss_o, .realign_o
  );

  assign sa_corrupt_o = loss_o & sys_sa_src_i & mode_en_i;
endmodule

// File: rtl/e1_biframe_mon_chk.sv
module e1_biframe_mon_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_start_i,
  input logic mode_en_i,
  input logic sys_sa_src_i,
  input logic loss_o,
  input logic realign_o,
  input logic ftype_vld_o,
  input logic sa_corrupt_o
);
  AST_REALIGN_CLEARS_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |-> !loss_o); // R5
  AST_REALIGN_FROM_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |-> $past(loss_o) && $past(mode_en_i)); // R5
  AST_DISABLED_NO_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> !loss_o && !realign_o); // R8
  AST_CORRUPT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sa_corrupt_o |-> loss_o && sys_sa_src_i && mode_en_i); // R7
  AST_LOSS_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loss_o) |-> $past(mode_en_i)); // R4
  AST_VLD_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !ftype_vld_o); // R3
endmodule

bind e1_biframe_mon e1_biframe_mon_chk u_chk (
  .clk_i, .rst_ni, .frame_start_i, .mode_en_i, .sys_sa_src_i,
  .loss_o, .realign_o, .ftype_vld_o, .sa_corrupt_o
);

// File: tb/e1_biframe_mon_tb_top.sv
`timescale 1ns/1ps
module e1_biframe_mon_tb_top;
  localparam int SB = 8;
  localparam int NS = 4;
  localparam int FB = SB * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0, dat = 1'b0, men = 1'b1, src = 1'b1;
  logic loss, realign, ftype, fvld, corrupt;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // model state
  bit m_loss, m_exp, m_prev, m_pv, m_realign;

  always #2 clk = ~clk;

  e1_biframe_mon #(.SLOT_BITS(SB), .SLOTS(NS), .TAP_POS(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .data_i(dat),
    .mode_en_i(men), .sys_sa_src_i(src),
    .loss_o(loss), .realign_o(realign), .frame_type_o(ftype),
    .ftype_vld_o(fvld), .sa_corrupt_o(corrupt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit b, input bit m);
    m_realign = 1'b0;
    if (!m) begin
      m_loss = 1'b0; m_pv = 1'b0; m_exp = ~b;
    end else if (!m_loss) begin
      if (b == m_exp) m_exp = ~b;
      else begin m_loss = 1'b1; m_prev = b; m_pv = 1'b1; end
    end else begin
      if (m_pv && m_prev && !b) begin
        m_loss = 1'b0; m_exp = 1'b1; m_realign = 1'b1; m_pv = 1'b0;
      end else begin m_prev = b; m_pv = 1'b1; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fs = 1'b0; dat = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_loss = 1'b1; m_exp = 1'b1; m_pv = 1'b0; m_prev = 1'b0; m_realign = 1'b0;
  endtask

  task automatic send_frame(input bit b, input bit m, input bit s);
    for (int i = 0; i < FB; i++) begin
      @(negedge clk);
      if (i == 1) check("R3 vld low after start", fvld, 1'b0);
      if (i == 2) begin
        model_step(b, m);
        check("R4/R5/R8 loss", loss, m_loss);
        check("R5 realign", realign, m_realign);
        check("R2 frame type", ftype, b);
        check("R7 corrupt", corrupt, m_loss & s & m);
      end
      if (i == 3)      check("R5 realign one cycle", realign, 1'b0);
      if (i == SB - 1) check("R3 vld before slot end", fvld, 1'b0);
      if (i == SB)     check("R3 vld after slot end", fvld, 1'b1);
      if (i == FB - 1) check("R3 vld held", fvld, 1'b1);
      fs  = (i == 0);
      dat = (i == 1) ? b : ((i % 3) == 0);
      men = m;
      src = s;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    men = 1'b1; src = 1'b1;
    do_reset();
    // R1: reset state, one cycle after release
    #1;
    check("R1 loss at reset", loss, 1'b1);
    check("R1 realign at reset", realign, 1'b0);
    check("R1 vld at reset", fvld, 1'b0);
    check("R7 corrupt at reset", corrupt, 1'b1);
    // R9: no strobe yet, data toggling: no sample, no valid
    for (int i = 0; i < 2 * FB; i++) begin
      @(negedge clk);
      dat = i[0];
    end
    check("R9 vld before first strobe", fvld, 1'b0);
    check("R9 still searching", loss, 1'b1);

    // R2 R4 R5 R6: every 7-frame type sequence, mode enabled
    for (int p = 0; p < 128; p++) begin
      do_reset();
      for (int f = 0; f < 7; f++) send_frame(p[f], 1'b1, p[f] ^ f[0]);
    end

    // R8: sweep with mode disabled on selected frames
    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int f = 0; f < 6; f++) begin
        bit m;
        m = !((f == 2 && p[6]) || (f == 4 && p[7]) || (f == 0 && p[6] && p[7]));
        send_frame(p[f], m, 1'b1);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule